// File: doc/BRIEF.md
# Level-Programmable Keypad Interrupt Controller

This peripheral watches eight key pins for a small microcontroller bus. Every pin is first brought into the clock domain by a synchroniser. It is then compared against its own software-chosen trigger level. When the pin sits at that level, a sticky per-pin flag is set. Software can mask each flag on its own. The flags that survive the mask are combined into one shared interrupt request, and a single global enable bit gates that request.

Detection is level based, so a key that is held down would raise its flag again straight after every acknowledge. To prevent this, each pin has a hold-off counter. The counter is loaded with a programmable value whenever the pin's flag sets. While the counter is nonzero, the flag cannot set again, so one press produces one event.

Software reaches the block through a small register port. The port has an address, a write strobe, write data and a combinational read. Flags are acknowledged by writing 1s to the flag register.

Top module: `kbd_irq_ctrl`

## Requirements
- R1: After reset the registers read: trigger level 0xFF (all pins active high), mask 0x00, flags 0x00, control 0x00 and hold-off reload 0x00. `irq_o` is low after reset.
- R2: The register addresses are: 0 = trigger level, 1 = mask, 2 = flags, 3 = control (bit 0 is the global enable), 4 = hold-off reload. Reads of addresses 5 to 7 return 0, and writes to those addresses change nothing.
- R3: A change on a key pin reaches its flag through two synchroniser flops. With the hold-off idle, the flag reads 1 after the third rising edge that follows the pin change, and not earlier.
- R4: Bit i of the trigger-level register selects the active level of pin i: 1 = active high, 0 = active low. A pin that is away from its active level never sets its flag.
- R5: A flag stays set after its pin leaves the active level. A flag clears only when 1 is written to its bit at address 2. Writing 0 to a flag bit leaves it unchanged.
- R6: If the pin is still active when its flag is cleared and the hold-off counter is idle, the flag reads 0 for exactly one cycle and then sets on the next edge.
- R7: When a flag sets, that pin's hold-off counter loads the reload value. The counter then counts down one step per clock. While the counter is nonzero the flag cannot set. A reload value of 0 disables the hold-off.
- R8: A flag whose mask bit is 0 still sets, but it never asserts `irq_o`.
- R9: When the global enable bit is 0, `irq_o` stays low.
- R10: `irq_o` is registered. It equals, one clock later, the OR over all pins of (flag AND mask), ANDed with the global enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_in | input | 8 | Asynchronous key pins |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The assertions check the following on every cycle:
- The interrupt output is the one-cycle-late masked and gated OR of the flags.
- A flag only rises when its pin was at the selected level and its hold-off counter was idle.
- A flag only falls under a write-1 acknowledge.
- The global enable and the mask suppress the request.

The bench scenarios are needed for the behaviour that depends on a sequence of events:
- the exact three-edge latency from a pin change to its flag;
- the one-cycle re-set after acknowledging a held key;
- the length of the hold-off window;
- the reset values and the register map.

A behavioural reference model also follows random stimulus and checks it.

// File: rtl/kbd_irq_pkg.sv
package kbd_irq_pkg;

    localparam int NUM_KEYS = 8;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_LEVEL = 3'd0,
        REG_MASK  = 3'd1,
        REG_FLAG  = 3'd2,
        REG_CTRL  = 3'd3,
        REG_HOLD  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [NUM_KEYS-1:0] level;
        logic [NUM_KEYS-1:0] mask;
        logic                gie;
    } kbd_cfg_t;

    localparam kbd_cfg_t CFG_RESET = '{level: '1, mask: '0, gie: 1'b0};

    // A pin is active when it equals its selected level bit.
    function automatic logic [NUM_KEYS-1:0] active_pins(
        input logic [NUM_KEYS-1:0] pins,
        input logic [NUM_KEYS-1:0] level
    );
        return ~(pins ^ level);
    endfunction

    function automatic logic is_write_to(
        input logic              we,
        input logic [ADDR_W-1:0] a,
        input reg_addr_e         target
    );
        return we && (a == target);
    endfunction

endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/kbd_pin_detect.sv
module kbd_pin_detect #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              clr,
    input  logic [HOLD_W-1:0] reload,
    output logic              flag,
    output logic              busy
);
    logic [HOLD_W-1:0] cnt_q;
    logic              set_now;

    assign busy    = (cnt_q != '0);
    assign set_now = active && !busy && !flag && !clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            cnt_q <= '0;
        end else begin
            if (clr) begin
                flag <= 1'b0;
            end else if (set_now) begin
                flag <= 1'b1;
            end

            if (set_now) begin
                cnt_q <= reload;
            end else if (busy) begin
                cnt_q <= cnt_q - HOLD_W'(1);
            end
        end
    end
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
    import kbd_irq_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [NUM_KEYS-1:0] flags,
    output kbd_cfg_t            cfg,
    output logic [HOLD_W-1:0]   reload,
    output logic [NUM_KEYS-1:0] clr_vec,
    output logic [DATA_W-1:0]   rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= CFG_RESET;
            reload <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_LEVEL: cfg.level <= wr_data[NUM_KEYS-1:0];
                REG_MASK:  cfg.mask  <= wr_data[NUM_KEYS-1:0];
                REG_CTRL:  cfg.gie   <= wr_data[0];
                REG_HOLD:  reload    <= wr_data[HOLD_W-1:0];
                default:   ;
            endcase
        end
    end

    assign clr_vec = is_write_to(wr_en, addr, REG_FLAG) ? wr_data[NUM_KEYS-1:0] : '0;

    always_comb begin
        case (addr)
            REG_LEVEL: rd_data = DATA_W'(cfg.level);
            REG_MASK:  rd_data = DATA_W'(cfg.mask);
            REG_FLAG:  rd_data = DATA_W'(flags);
            REG_CTRL:  rd_data = DATA_W'(cfg.gie);
            REG_HOLD:  rd_data = DATA_W'(reload);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/kbd_irq_ctrl.sv
module kbd_irq_ctrl
    import kbd_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_W      = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_KEYS-1:0] key_in,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq_o
);
    kbd_cfg_t            cfg;
    logic [HOLD_W-1:0]   reload;
    logic [NUM_KEYS-1:0] clr_vec;
    logic [NUM_KEYS-1:0] pins_sync;
    logic [NUM_KEYS-1:0] act_vec;
    logic [NUM_KEYS-1:0] flag_vec;
    logic [NUM_KEYS-1:0] busy_vec;
    logic [NUM_KEYS-1:0] mask_vec;
    logic                gie_bit;

    kbd_sync #(.WIDTH(NUM_KEYS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (key_in),
        .q   (pins_sync)
    );

    kbd_regs #(.HOLD_W(HOLD_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .flags   (flag_vec),
        .cfg     (cfg),
        .reload  (reload),
        .clr_vec (clr_vec),
        .rd_data (rd_data)
    );

    assign act_vec  = active_pins(pins_sync, cfg.level);
    assign mask_vec = cfg.mask;
    assign gie_bit  = cfg.gie;

    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_pin
        kbd_pin_detect #(.HOLD_W(HOLD_W)) u_pin (
            .clk    (clk),
            .rst    (rst),
            .active (act_vec[i]),
            .clr    (clr_vec[i]),
            .reload (reload),
            .flag   (flag_vec[i]),
            .busy   (busy_vec[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= gie_bit && (|(flag_vec & mask_vec));
        end
    end
endmodule

// File: rtl/kbd_irq_chk.sv
module kbd_irq_chk
    import kbd_irq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic [NUM_KEYS-1:0] flag,
    input logic [NUM_KEYS-1:0] mask,
    input logic                gie,
    input logic [NUM_KEYS-1:0] busy,
    input logic [NUM_KEYS-1:0] active,
    input logic                irq
);
    a_r10_irq_registered: assert property (@(posedge clk) disable iff (rst)
        irq == $past(gie && (|(flag & mask))));

    a_r9_gie_gates: assert property (@(posedge clk) disable iff (rst)
        !$past(gie) |-> !irq);

    a_r8_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|(flag & mask)));

    a_r4_rise_needs_level: assert property (@(posedge clk) disable iff (rst)
        ((flag & ~$past(flag) & ~$past(active)) == '0));

    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && addr == REG_FLAG) |-> ((flag & $past(wr_data[NUM_KEYS-1:0])) == '0));

    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        ((~flag & $past(flag)
          & ~$past((wr_en && addr == REG_FLAG) ? wr_data[NUM_KEYS-1:0] : '0)) == '0));

    a_r7_holdoff_blocks: assert property (@(posedge clk) disable iff (rst)
        ((flag & ~$past(flag) & $past(busy)) == '0));
endmodule

bind kbd_irq_ctrl kbd_irq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .flag    (flag_vec),
    .mask    (mask_vec),
    .gie     (gie_bit),
    .busy    (busy_vec),
    .active  (act_vec),
    .irq     (irq_o)
);

// File: tb/kbd_irq_ctrl_test.sv
`timescale 1ns/1ps
module kbd_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] key_in = 8'h00;
    logic [2:0] addr = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_flag = 1'b0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    kbd_irq_ctrl uut (
        .clk(clk), .rst(rst), .key_in(key_in), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    // Behavioural reference model, updated at each rising edge.
    logic [7:0] m_s1, m_s2, m_lvl, m_en, m_flag;
    logic       m_gie, m_irq;
    int         m_cnt [8];
    int         m_reload;

    always @(posedge clk) begin
        logic [7:0] nflag;
        logic       nirq;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_lvl = 8'hFF; m_en = 0; m_flag = 0;
            m_gie = 0; m_irq = 0; m_reload = 0;
            for (int i = 0; i < 8; i++) m_cnt[i] = 0;
        end else begin
            nirq  = m_gie && ((m_flag & m_en) != 0);
            nflag = m_flag;
            for (int i = 0; i < 8; i++) begin
                if (wr_en && addr == 3'd2 && wr_data[i]) begin
                    nflag[i] = 0;
                    if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
                end else if (m_s2[i] == m_lvl[i] && m_cnt[i] == 0 && !m_flag[i]) begin
                    nflag[i] = 1;
                    m_cnt[i] = m_reload;
                end else if (m_cnt[i] > 0) begin
                    m_cnt[i] = m_cnt[i] - 1;
                end
            end
            if (wr_en) begin
                case (addr)
                    3'd0: m_lvl = wr_data;
                    3'd1: m_en = wr_data;
                    3'd3: m_gie = wr_data[0];
                    3'd4: m_reload = int'(wr_data);
                    default: ;
                endcase
            end
            m_flag = nflag;
            m_irq  = nirq;
            m_s2 = m_s1;
            m_s1 = key_in;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            n_tests++;
            if (irq_o !== m_irq) begin
                n_fail++;
                $display("FAIL R10 model irq: actual %0b expected %0b at %0t", irq_o, m_irq, $time);
            end
            if (cmp_flag) begin
                n_tests++;
                if (rd_data !== m_flag) begin
                    n_fail++;
                    $display("FAIL R5 model flags: actual %02h expected %02h at %0t", rd_data, m_flag, $time);
                end
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        #1 addr = a;
        #1 v = rd_data;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        peek(a, v);
    endtask

    task automatic set_keys(input logic [7:0] k);
        @(negedge clk); #1 key_in = k;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        rd(3'd0, rv); check("R1 level", rv, 8'hFF);
        rd(3'd1, rv); check("R1 mask", rv, 8'h00);
        rd(3'd2, rv); check("R1 flags", rv, 8'h00);
        rd(3'd3, rv); check("R1 ctrl", rv, 8'h00);
        rd(3'd4, rv); check("R1 reload", rv, 8'h00);
        check("R1 irq", {7'b0, irq_o}, 8'h00);

        // R2 map and unused addresses
        wr(3'd4, 8'h5A); rd(3'd4, rv); check("R2 reload rw", rv, 8'h5A);
        wr(3'd5, 8'hFF); rd(3'd5, rv); check("R2 unused addr reads 0", rv, 8'h00);
        rd(3'd1, rv); check("R2 unused write no effect", rv, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd1, 8'h01);
        wr(3'd3, 8'h01);

        // R3 latency, R10 registered irq
        set_keys(8'h01);
        rd(3'd2, rv); check("R3 after edge 1", rv, 8'h00);
        rd(3'd2, rv); check("R3 after edge 2", rv, 8'h00);
        rd(3'd2, rv); check("R3 after edge 3", rv, 8'h01);
        check("R10 irq not yet", {7'b0, irq_o}, 8'h00);
        rd(3'd2, rv); check("R10 irq one cycle later", {7'b0, irq_o}, 8'h01);

        // R6 clear while held
        wr(3'd2, 8'h01);
        peek(3'd2, rv); check("R6 cleared for one cycle", rv, 8'h00);
        rd(3'd2, rv); check("R6 set again", rv, 8'h01);

        // R5 sticky and write-1-to-clear
        set_keys(8'h00);
        repeat (4) @(negedge clk);
        rd(3'd2, rv); check("R5 sticky after release", rv, 8'h01);
        wr(3'd2, 8'h00); rd(3'd2, rv); check("R5 write 0 no effect", rv, 8'h01);
        wr(3'd2, 8'h01); rd(3'd2, rv); check("R5 write 1 clears", rv, 8'h00);

        // R4 active-low selection
        set_keys(8'h08);
        repeat (4) @(negedge clk);
        wr(3'd0, 8'hF7);
        wr(3'd2, 8'hFF);
        repeat (4) @(negedge clk);
        rd(3'd2, rv); check("R4 inactive high on low pin", rv & 8'h08, 8'h00);
        set_keys(8'h00);
        repeat (4) @(negedge clk);
        rd(3'd2, rv); check("R4 low pin flagged", rv & 8'h08, 8'h08);

        // R8 mask, R9 global enable
        rd(3'd2, rv); check("R8 irq masked", {7'b0, irq_o}, 8'h00);
        wr(3'd1, 8'hFF);
        rd(3'd2, rv); check("R8 irq when unmasked", {7'b0, irq_o}, 8'h01);
        wr(3'd3, 8'h00);
        rd(3'd2, rv); check("R9 irq off with gie 0", {7'b0, irq_o}, 8'h00);

        // R7 hold-off
        wr(3'd0, 8'hFF);
        wr(3'd4, 8'd10);
        wr(3'd2, 8'hFF);
        set_keys(8'h20);
        repeat (4) @(negedge clk);
        rd(3'd2, rv); check("R7 first set", rv, 8'h20);
        wr(3'd2, 8'h20);
        peek(3'd2, rv); check("R7 cleared", rv, 8'h00);
        rd(3'd2, rv); rd(3'd2, rv); rd(3'd2, rv);
        check("R7 suppressed during hold-off", rv, 8'h00);
        repeat (10) @(negedge clk);
        rd(3'd2, rv); check("R7 set after hold-off", rv, 8'h20);

        // Random phases against the model
        for (int ph = 0; ph < 2; ph++) begin
            wr(3'd0, 8'($urandom));
            wr(3'd1, 8'($urandom));
            wr(3'd3, 8'h01);
            wr(3'd4, (ph == 0) ? 8'd0 : 8'd3);
            @(negedge clk); #1 addr = 3'd2;
            @(negedge clk);
            cmp_flag = 1'b1;
            for (int c = 0; c < 400; c++) begin
                @(negedge clk); #1;
                key_in  = 8'($urandom);
                wr_en   = ($urandom % 4 == 0);
                wr_data = 8'($urandom);
            end
            @(negedge clk); #1 wr_en = 1'b0;
            cmp_flag = 1'b0;
        end

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule